// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits between a serial-memory protocol engine and the storage array. During a write sequence the engine hands it data bytes one at a time. The block keeps them in a page-sized holding buffer and marks each byte slot that has been filled. A page may be filled only in part. If more bytes arrive than the page holds, the in-page offset wraps, and later bytes replace the ones held at the same offset.

The buffer reaches the array only when the engine reports a STOP that closes a write sequence. The block then reports busy. It waits a programmable number of clock cycles that stands for the programming time. It then writes each filled slot to the array, one byte per cycle, in ascending offset order. While busy, it refuses every access: an address match yields no acknowledge, and sequence starts, byte strobes and STOPs are dropped. A controller can therefore poll with address phases until it sees an acknowledge again. A write-protect input held high at the STOP cancels the commit, so the block never goes busy.

Top module: `pgwr_ctrl`

## Requirements
- R1: A sequence start loads the page row from the upper bits of `start_addr_i` and the byte offset from its low 5 bits. Each accepted byte goes to the current offset, and the offset then increments. A commit writes byte `d` at array address `{row, offset}`, and a partial page writes only the bytes received.
- R2: The offset wraps from 31 to 0 inside the same row. When more than 32 bytes are sent, each offset holds the last byte sent to it.
- R3: No array write occurs before a STOP. A new sequence start discards all bytes buffered by an earlier sequence that got no STOP.
- R4: A STOP accepted while idle, with `wp_i` low and at least one byte buffered, raises `busy_o` on the next cycle. The first array write comes exactly `TWR_CYCLES` cycles after `busy_o` rises.
- R5: Commit writes come on consecutive cycles, one per buffered offset, in strictly ascending offset order. Offsets never received are skipped.
- R6: `busy_o` falls in the cycle right after the last array write, so a commit of n bytes keeps `busy_o` high for `TWR_CYCLES + n` cycles.
- R7: While `busy_o` is high, `addr_ack_o` stays low even when `addr_hit_i` is high. While idle, `addr_ack_o` is high whenever `addr_hit_i` is high.
- R8: While busy, `seq_start_i`, `byte_we_i` and `stop_wr_i` have no effect. Bytes offered then are never written, and a STOP after the commit finds nothing to write.
- R9: A STOP with `wp_i` high writes nothing and leaves `busy_o` low, so an address match is acknowledged on the next cycle.
- R10: A STOP with no byte buffered writes nothing and leaves `busy_o` low.
- R11: `arr_we_o` is never high while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seq_start_i | input | 1 | A new write sequence begins; clears buffered bytes |
| start_addr_i | input | ROW_W+5 | Start word address: row in upper bits, offset in low bits |
| byte_we_i | input | 1 | Data byte strobe |
| byte_data_i | input | DATA_W | Data byte |
| stop_wr_i | input | 1 | STOP seen after a write sequence |
| wp_i | input | 1 | Write protect; high blocks the commit |
| addr_hit_i | input | 1 | Device address matched in the current address phase |
| addr_ack_o | output | 1 | Acknowledge the matched address |
| busy_o | output | 1 | Timed write cycle in progress |
| arr_we_o | output | 1 | Array byte write strobe |
| arr_addr_o | output | ROW_W+5 | Array byte address |
| arr_data_o | output | DATA_W | Array write data |

## Verification
Two functions can fall in the same cycle: the last array write of a commit, and an address poll from the controller. To provoke this, the bench holds `addr_hit_i` high through a whole commit. It then requires no acknowledge in the cycle of the final write, and an acknowledge one cycle later, once `busy_o` has dropped. Early in the same busy window it also offers a sequence start, bytes and a STOP together. After that commit it sends a lone STOP and expects no new busy period and no write, which shows the busy-time inputs were dropped rather than buffered.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WAIT  = 2'd1,
      ST_DRAIN = 2'd2
   } pgwr_state_e;
endpackage

// File: rtl/pgwr_store.sv
// Page holding buffer: byte slots, fill flags and the wrapping offset pointer.
module pgwr_store #(
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 32,
   localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr_i,
   input  logic [OFF_W-1:0]      load_off_i,
   input  logic                  put_i,
   input  logic [DATA_W-1:0]     put_data_i,
   input  logic                  take_i,
   input  logic [OFF_W-1:0]      take_idx_i,
   output logic [PAGE_BYTES-1:0] full_o,
   output logic [DATA_W-1:0]     take_data_o
);
   logic [DATA_W-1:0] slot_q [PAGE_BYTES];
   logic [OFF_W-1:0]  ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         full_o <= '0;
         for (int i = 0; i < PAGE_BYTES; i++) slot_q[i] <= '0;
      end else if (clr_i) begin
         ptr_q  <= load_off_i;
         full_o <= '0;
      end else begin
         if (put_i) begin
            slot_q[ptr_q] <= put_data_i;
            full_o[ptr_q] <= 1'b1;
            ptr_q         <= ptr_q + 1'b1;
         end
         if (take_i) full_o[take_idx_i] <= 1'b0;
      end
   end

   assign take_data_o = slot_q[take_idx_i];
endmodule

// File: rtl/pgwr_pick.sv
// Lowest-set-bit selector over the fill flags.
module pgwr_pick #(
   parameter int N = 32,
   localparam int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     req_i,
   output logic             any_o,
   output logic             last_o,
   output logic [IDX_W-1:0] idx_o
);
   logic [N:0]   none_below;
   logic [N-1:0] grant;

   assign none_below[0] = 1'b1;
   for (genvar g = 0; g < N; g++) begin : g_chain
      assign grant[g]        = req_i[g] & none_below[g];
      assign none_below[g+1] = none_below[g] & ~req_i[g];
   end

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < N; i++)
         if (grant[i]) idx_o = idx_o | IDX_W'(i);
   end

   assign any_o  = ~none_below[N];
   assign last_o = ((req_i & ~grant) == '0);
endmodule

// File: rtl/pgwr_timer.sv
// Down-counter standing in for the programming time.
module pgwr_timer #(
   parameter int TWR_CYCLES = 250000,
   localparam int CNT_W     = $clog2(TWR_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic run_i,
   output logic zero_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt_q <= '0;
      else if (load_i)                cnt_q <= CNT_W'(TWR_CYCLES - 1);
      else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl #(
   parameter int DATA_W     = 8,
   parameter int PAGE_BYTES = 32,
   parameter int ROW_W      = 8,
   parameter int TWR_CYCLES = 250000,
   localparam int OFF_W     = $clog2(PAGE_BYTES),
   localparam int ADDR_W    = ROW_W + OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seq_start_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic              byte_we_i,
   input  logic [DATA_W-1:0] byte_data_i,
   input  logic              stop_wr_i,
   input  logic              wp_i,
   input  logic              addr_hit_i,
   output logic              addr_ack_o,
   output logic              busy_o,
   output logic              arr_we_o,
   output logic [ADDR_W-1:0] arr_addr_o,
   output logic [DATA_W-1:0] arr_data_o
);
   import pgwr_pkg::*;

   if ((1 << OFF_W) != PAGE_BYTES) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two");
   end
   if (TWR_CYCLES < 1) begin : g_bad_twr
      $error("TWR_CYCLES must be at least 1");
   end
   if (ROW_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("ROW_W and DATA_W must be positive");
   end

   pgwr_state_e       state_q;
   logic [ROW_W-1:0]  row_q;
   logic [PAGE_BYTES-1:0] full;
   logic              vld_any, vld_last, tmr_zero;
   logic [OFF_W-1:0]  pick_idx;
   logic              idle, acc_seq, acc_byte, commit_go, draining;

   assign idle      = (state_q == ST_IDLE);
   assign acc_seq   = seq_start_i & idle;
   assign acc_byte  = byte_we_i & idle;
   assign commit_go = stop_wr_i & idle & ~wp_i & vld_any;
   assign draining  = (state_q == ST_DRAIN);

   pgwr_store #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (acc_seq),
      .load_off_i (start_addr_i[OFF_W-1:0]),
      .put_i      (acc_byte),
      .put_data_i (byte_data_i),
      .take_i     (draining),
      .take_idx_i (pick_idx),
      .full_o     (full),
      .take_data_o(arr_data_o)
   );

   pgwr_pick #(.N(PAGE_BYTES)) u_pick (
      .req_i (full),
      .any_o (vld_any),
      .last_o(vld_last),
      .idx_o (pick_idx)
   );

   pgwr_timer #(.TWR_CYCLES(TWR_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(commit_go),
      .run_i (state_q == ST_WAIT),
      .zero_o(tmr_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       row_q <= '0;
      else if (acc_seq) row_q <= start_addr_i[ADDR_W-1:OFF_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else begin
         unique case (state_q)
            ST_IDLE:  if (commit_go) state_q <= ST_WAIT;
            ST_WAIT:  if (tmr_zero)  state_q <= ST_DRAIN;
            ST_DRAIN: if (vld_last)  state_q <= ST_IDLE;
            default:                 state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o     = ~idle;
   assign addr_ack_o = addr_hit_i & idle;
   assign arr_we_o   = draining;
   assign arr_addr_o = {row_q, pick_idx};
endmodule

// File: rtl/pgwr_ctrl_chk.sv
module pgwr_ctrl_chk #(
   parameter int TWR_CYCLES = 250000,
   parameter int ADDR_W     = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy_o,
   input logic              arr_we_o,
   input logic [ADDR_W-1:0] arr_addr_o,
   input logic              stop_wr_i,
   input logic              wp_i,
   input logic              vld_any,
   input logic              addr_hit_i,
   input logic              addr_ack_o
);
   int unsigned wait_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        wait_cnt <= 0;
      else if (!busy_o)  wait_cnt <= 0;
      else if (!arr_we_o) wait_cnt <= wait_cnt + 1;
   end

   AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !arr_we_o); // R11
   AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && stop_wr_i && wp_i) |=> !busy_o); // R9
   AST_COMMIT_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && stop_wr_i && !wp_i && vld_any) |=> busy_o); // R4
   AST_WAIT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_we_o && !$past(arr_we_o)) |-> (wait_cnt == TWR_CYCLES)); // R4
   AST_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_we_o && $past(arr_we_o)) |-> (arr_addr_o > $past(arr_addr_o))); // R5
   AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> $past(arr_we_o)); // R6
   AST_NACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && addr_hit_i) |-> !addr_ack_o); // R7
endmodule

bind pgwr_ctrl pgwr_ctrl_chk #(.TWR_CYCLES(TWR_CYCLES), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy_o    (busy_o),
   .arr_we_o  (arr_we_o),
   .arr_addr_o(arr_addr_o),
   .stop_wr_i (stop_wr_i),
   .wp_i      (wp_i),
   .vld_any   (vld_any),
   .addr_hit_i(addr_hit_i),
   .addr_ack_o(addr_ack_o)
);

// File: tb/tb_pgwr_ctrl.sv
module tb_pgwr_ctrl;
   localparam int TWR    = 20;
   localparam int ADDR_W = 13;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              seq_start_i = 1'b0;
   logic [ADDR_W-1:0] start_addr_i = '0;
   logic              byte_we_i = 1'b0;
   logic [7:0]        byte_data_i = '0;
   logic              stop_wr_i = 1'b0;
   logic              wp_i = 1'b0;
   logic              addr_hit_i = 1'b0;
   logic              addr_ack_o, busy_o, arr_we_o;
   logic [ADDR_W-1:0] arr_addr_o;
   logic [7:0]        arr_data_o;

   int total = 0;
   int bad   = 0;

   pgwr_ctrl #(.DATA_W(8), .PAGE_BYTES(32), .ROW_W(8), .TWR_CYCLES(TWR)) dut (
      .clk(clk), .rst_n(rst_n), .seq_start_i(seq_start_i), .start_addr_i(start_addr_i),
      .byte_we_i(byte_we_i), .byte_data_i(byte_data_i), .stop_wr_i(stop_wr_i),
      .wp_i(wp_i), .addr_hit_i(addr_hit_i), .addr_ack_o(addr_ack_o), .busy_o(busy_o),
      .arr_we_o(arr_we_o), .arr_addr_o(arr_addr_o), .arr_data_o(arr_data_o)
   );

   always #10 clk = ~clk;

   // write log filled by observer
   logic [ADDR_W-1:0] log_addr [64];
   logic [7:0]        log_data [64];
   int                wr_n = 0;

   always @(negedge clk) begin
      if (arr_we_o && wr_n < 64) begin
         log_addr[wr_n] = arr_addr_o;
         log_data[wr_n] = arr_data_o;
         wr_n = wr_n + 1;
      end
   end

   // bench model
   logic [7:0]  m_buf [32];
   logic [31:0] m_vld = '0;
   logic [7:0]  m_row = '0;
   logic [4:0]  m_off = '0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic seq(input logic [ADDR_W-1:0] a);
      @(negedge clk); seq_start_i = 1'b1; start_addr_i = a;
      @(negedge clk); seq_start_i = 1'b0;
      m_vld = '0; m_row = a[12:5]; m_off = a[4:0];
   endtask

   task automatic put(input logic [7:0] d);
      @(negedge clk); byte_we_i = 1'b1; byte_data_i = d;
      @(negedge clk); byte_we_i = 1'b0;
      m_buf[m_off] = d; m_vld[m_off] = 1'b1; m_off = m_off + 5'd1;
   endtask

   // compare logged writes against model list (ascending offsets)
   task automatic cmp_log(input string req);
      int k = 0;
      for (int o = 0; o < 32; o++) begin
         if (m_vld[o]) begin
            chk(k < wr_n && log_addr[k] == {m_row, 5'(o)}, req, int'(log_addr[k]), int'({m_row, 5'(o)}));
            chk(k < wr_n && log_data[k] == m_buf[o], req, int'(log_data[k]), int'(m_buf[o]));
            k++;
         end
      end
      chk(wr_n == k, req, wr_n, k);
   endtask

   // STOP then follow busy period; returns busy length and first write index
   task automatic stop_run(input bit wp, output int blen, output int first);
      wr_n = 0;
      @(negedge clk); stop_wr_i = 1'b1; wp_i = wp;
      @(negedge clk); stop_wr_i = 1'b0; wp_i = 1'b0;
      blen = 0; first = -1;
      while (busy_o && blen < 2000) begin
         if (arr_we_o && first < 0) first = blen;
         blen++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset;
      chk(busy_o == 1'b0, "R11 reset busy", busy_o, 0);
      chk(arr_we_o == 1'b0, "R11 reset we", arr_we_o, 0);
      addr_hit_i = 1'b1; #1;
      chk(addr_ack_o == 1'b1, "R7 idle ack", addr_ack_o, 1);
      addr_hit_i = 1'b0;
   endtask

   task automatic t_partial;
      int bl, fw, n;
      seq({8'd5, 5'd3});
      put(8'h11); put(8'h22); put(8'h33); put(8'h44);
      n = $countones(m_vld);
      stop_run(1'b0, bl, fw);
      chk(fw == TWR, "R4 first write delay", fw, TWR);
      chk(bl == TWR + n, "R6 busy length", bl, TWR + n);
      cmp_log("R1 R5 partial page");
      m_vld = '0;
   endtask

   task automatic t_wrap;
      int bl, fw;
      seq({8'd9, 5'd30});
      for (int i = 0; i < 35; i++) put(8'(8'h40 + i));
      stop_run(1'b0, bl, fw);
      chk(bl == TWR + 32, "R6 full page busy", bl, TWR + 32);
      cmp_log("R2 wrap overwrite");
      m_vld = '0;
   endtask

   task automatic t_nostop;
      int bl, fw, seen = 0;
      seq({8'd2, 5'd0});
      put(8'hA1); put(8'hA2); put(8'hA3);
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (arr_we_o || busy_o) seen++;
      end
      chk(seen == 0, "R3 no write before stop", seen, 0);
      seq({8'd3, 5'd10});
      put(8'h5C);
      stop_run(1'b0, bl, fw);
      cmp_log("R3 stale bytes dropped");
      m_vld = '0;
   endtask

   task automatic t_busy_poll;
      int c = 0, acks = 0, last_ack = -1, bl, fw;
      seq({8'd7, 5'd0});
      put(8'h01); put(8'h02); put(8'h03);
      wr_n = 0;
      @(negedge clk); stop_wr_i = 1'b1; addr_hit_i = 1'b1;
      @(negedge clk); stop_wr_i = 1'b0;
      while (busy_o && c < 2000) begin
         if (c == 2) begin
            seq_start_i = 1'b1; start_addr_i = {8'd100, 5'd0};
            byte_we_i = 1'b1; byte_data_i = 8'hEE; stop_wr_i = 1'b1;
         end
         if (c == 8) begin
            seq_start_i = 1'b0; byte_we_i = 1'b0; stop_wr_i = 1'b0;
         end
         #1;
         if (addr_ack_o) acks++;
         if (c == TWR + 2) last_ack = int'(addr_ack_o);
         c++;
         @(negedge clk);
      end
      #1;
      chk(acks == 0, "R7 nack while busy", acks, 0);
      chk(last_ack == 0, "R7 nack on last write", last_ack, 0);
      chk(addr_ack_o == 1'b1, "R7 ack after busy", addr_ack_o, 1);
      addr_hit_i = 1'b0;
      cmp_log("R8 busy inputs ignored");
      m_vld = '0;
      stop_run(1'b0, bl, fw);
      chk(bl == 0, "R8 no buffered junk", bl, 0);
      chk(wr_n == 0, "R10 empty stop writes", wr_n, 0);
   endtask

   task automatic t_wp;
      int bl, fw;
      seq({8'd12, 5'd4});
      put(8'h77); put(8'h78);
      stop_run(1'b1, bl, fw);
      chk(bl == 0, "R9 wp no busy", bl, 0);
      chk(wr_n == 0, "R9 wp no write", wr_n, 0);
      addr_hit_i = 1'b1; #1;
      chk(addr_ack_o == 1'b1, "R9 ack after wp stop", addr_ack_o, 1);
      addr_hit_i = 1'b0;
      seq({8'd12, 5'd31});
      put(8'h99);
      stop_run(1'b0, bl, fw);
      chk(bl == TWR + 1, "R6 single byte busy", bl, TWR + 1);
      cmp_log("R1 after wp");
      m_vld = '0;
   endtask

   task automatic t_empty;
      int bl, fw;
      seq({8'd20, 5'd0});
      stop_run(1'b0, bl, fw);
      chk(bl == 0, "R10 empty no busy", bl, 0);
      chk(wr_n == 0, "R10 empty no write", wr_n, 0);
   endtask

   bit finished = 1'b0;

   initial begin
      #(20 * 150000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog act=0 exp=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_partial();
      t_wrap();
      t_nostop();
      t_busy_poll();
      t_wp();
      t_empty();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule